// File: doc/BRIEF.md
# Ramp Pattern Self-Test Source and Monitor

This block is a built-in self-test pair for a byte-wide link that carries a control-character flag beside each byte, as an 8b/10b encoder and decoder would. The source side emits an endless 8-bit counting ramp. After a fixed number of complete ramps it sends one comma control character. The monitor side watches received byte/flag pairs. It waits until it sees the exact start of a ramp, and from then on it flags every data byte that does not follow its predecessor by one.

Both halves share one clock and one synchronous active-high reset. Each half has its own enable. In a system the source feeds a transmit path and the monitor sits on the matching receive path. The serial encoding and the line itself are outside the block. The number of ramps between commas is set by the width of a ramp counter, `RAMP_CNT_W`: a comma follows every 2^`RAMP_CNT_W` ramps.

Top module: `ramp_bist`

## Requirements
- R1: While the source is enabled, its non-control output bytes count up by one per cycle from 0x00 and wrap from 0xFF to 0x00. The first byte after enable is 0x00 and appears one cycle after the first enabled clock edge.
- R2: The source's control flag is high only for the comma, which is the byte 0xBC with the flag set to 1.
- R3: Exactly one comma follows the 0xFF byte that completes every 2^RAMP_CNT_W-th ramp. The ramp then restarts at 0x00, so two commas are never adjacent.
- R4: The monitor raises active one cycle after it has received the data bytes 0x00, 0x01 and 0x02 on consecutive cycles with the flag low. A wrong byte restarts the search, and a 0x00 counts as the first byte of a new search. Any flagged input during the search restarts it.
- R5: Once active, a data byte that differs from the previous data byte plus one (modulo 256) sets err one cycle later. err stays set, and the received byte becomes the new reference.
- R6: A received comma clears err one cycle later. It takes no part in the comparison, and the last data byte remains the reference across it.
- R7: A flagged input whose byte is not 0xBC neither sets nor clears err, and leaves the reference unchanged.
- R8: Reset, or a low enable, clears that half on the next edge. The source then outputs 0x00 with the flag low and its counters restart. The monitor drops active and err and restarts its search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both halves |
| rst | input | 1 | Synchronous active-high reset |
| gen_en | input | 1 | Source enable |
| gen_data_o | output | 8 | Source byte |
| gen_k_o | output | 1 | Source control-character flag |
| chk_en | input | 1 | Monitor enable |
| chk_data_i | input | 8 | Received byte |
| chk_k_i | input | 1 | Received control-character flag |
| chk_active_o | output | 1 | Ramp start found, comparison running |
| chk_err_o | output | 1 | Sequence break seen since the last comma |

## Verification
The hardest state to reach from the ports is a broken sequence that lasts across a comma boundary. The error has to be raised mid-ramp and then held until the next comma, and the comma must clear it without breaking the 0xFF to 0x00 continuity check. The bench loops the source into the monitor with a narrow ramp counter, so a comma arrives within a few hundred cycles. It corrupts a single looped byte, then keeps looping through the next comma. Hand-built sequences then drive the search restarts, a flagged non-comma byte, and the reference being held across a comma, all checked against a behavioural model on every clock.

// File: rtl/ramp_bist_pkg.sv
package ramp_bist_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] COMMA_BYTE = 8'hBC;
  localparam logic [BYTE_W-1:0] RAMP_LAST  = {BYTE_W{1'b1}};

  typedef enum logic [1:0] {
    SEEK_B0 = 2'd0,
    SEEK_B1 = 2'd1,
    SEEK_B2 = 2'd2
  } seek_t;
endpackage

// File: rtl/ramp_gen.sv
module ramp_gen
  import ramp_bist_pkg::*;
#(
  parameter int RAMP_CNT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  output logic [BYTE_W-1:0] data_o,
  output logic              k_o
);
  localparam logic [RAMP_CNT_W-1:0] RAMPS_LAST = {RAMP_CNT_W{1'b1}};

  logic [BYTE_W-1:0]     ramp_q;
  logic [RAMP_CNT_W-1:0] ramps_q;
  logic                  comma_due_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      ramp_q      <= '0;
      ramps_q     <= '0;
      comma_due_q <= 1'b0;
      data_o      <= '0;
      k_o         <= 1'b0;
    end else if (comma_due_q) begin
      data_o      <= COMMA_BYTE;
      k_o         <= 1'b1;
      comma_due_q <= 1'b0;
    end else begin
      data_o <= ramp_q;
      k_o    <= 1'b0;
      ramp_q <= ramp_q + 1'b1;
      if (ramp_q == RAMP_LAST) begin
        ramps_q <= ramps_q + 1'b1;
        if (ramps_q == RAMPS_LAST) comma_due_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ramp_chk.sv
module ramp_chk
  import ramp_bist_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              k_i,
  output logic              active_o,
  output logic              err_o
);
  seek_t             seek_q;
  logic [BYTE_W-1:0] ref_q;
  logic [BYTE_W-1:0] expect_w;
  seek_t             restart_w;

  assign expect_w  = ref_q + 1'b1;
  assign restart_w = (data_i == '0) ? SEEK_B1 : SEEK_B0;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      seek_q   <= SEEK_B0;
      ref_q    <= '0;
      active_o <= 1'b0;
      err_o    <= 1'b0;
    end else if (k_i) begin
      if (data_i == COMMA_BYTE) err_o <= 1'b0;
      if (!active_o) seek_q <= SEEK_B0;
    end else if (!active_o) begin
      ref_q <= data_i;
      unique case (seek_q)
        SEEK_B0: seek_q <= restart_w;
        SEEK_B1: seek_q <= (data_i == 8'h01) ? SEEK_B2 : restart_w;
        SEEK_B2: begin
          if (data_i == 8'h02) begin
            active_o <= 1'b1;
            seek_q   <= SEEK_B0;
          end else begin
            seek_q <= restart_w;
          end
        end
        default: seek_q <= SEEK_B0;
      endcase
    end else begin
      if (data_i != expect_w) err_o <= 1'b1;
      ref_q <= data_i;
    end
  end
endmodule

// File: rtl/ramp_bist.sv
module ramp_bist
  import ramp_bist_pkg::*;
#(
  parameter int RAMP_CNT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gen_en,
  output logic [BYTE_W-1:0] gen_data_o,
  output logic              gen_k_o,
  input  logic              chk_en,
  input  logic [BYTE_W-1:0] chk_data_i,
  input  logic              chk_k_i,
  output logic              chk_active_o,
  output logic              chk_err_o
);
  ramp_gen #(.RAMP_CNT_W(RAMP_CNT_W)) u_gen (
    .clk    (clk),
    .rst    (rst),
    .en     (gen_en),
    .data_o (gen_data_o),
    .k_o    (gen_k_o)
  );

  ramp_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (chk_en),
    .data_i   (chk_data_i),
    .k_i      (chk_k_i),
    .active_o (chk_active_o),
    .err_o    (chk_err_o)
  );
endmodule

// File: rtl/ramp_bist_sva.sv
module ramp_bist_sva
  import ramp_bist_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              gen_en,
  input logic [BYTE_W-1:0] gen_data_o,
  input logic              gen_k_o,
  input logic              chk_en,
  input logic [BYTE_W-1:0] chk_data_i,
  input logic              chk_k_i,
  input logic              chk_active_o,
  input logic              chk_err_o
);
  AST_RAMP_STEP: assert property (@(posedge clk) disable iff (rst)
    ($past(gen_en) && $past(gen_en, 2) && !$past(rst) && !$past(rst, 2) && !gen_k_o && !$past(gen_k_o))
      |-> (gen_data_o == $past(gen_data_o) + 8'd1)); // R1
  AST_K_IS_COMMA: assert property (@(posedge clk) disable iff (rst)
    gen_k_o |-> (gen_data_o == COMMA_BYTE)); // R2
  AST_COMMA_SINGLE: assert property (@(posedge clk) disable iff (rst)
    gen_k_o |=> !gen_k_o); // R3
  AST_ACTIVE_AFTER_02: assert property (@(posedge clk) disable iff (rst)
    $rose(chk_active_o) |-> ($past(chk_data_i) == 8'h02 && !$past(chk_k_i))); // R4
  AST_ERR_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    chk_err_o |-> chk_active_o); // R5
  AST_COMMA_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (chk_en && chk_k_i && chk_data_i == COMMA_BYTE) |=> !chk_err_o); // R6
  AST_GEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !gen_en |=> (gen_data_o == '0 && !gen_k_o)); // R8
  AST_CHK_IDLE: assert property (@(posedge clk) disable iff (rst)
    !chk_en |=> (!chk_active_o && !chk_err_o)); // R8
endmodule

bind ramp_bist ramp_bist_sva u_sva (
  .clk          (clk),
  .rst          (rst),
  .gen_en       (gen_en),
  .gen_data_o   (gen_data_o),
  .gen_k_o      (gen_k_o),
  .chk_en       (chk_en),
  .chk_data_i   (chk_data_i),
  .chk_k_i      (chk_k_i),
  .chk_active_o (chk_active_o),
  .chk_err_o    (chk_err_o)
);

// File: tb/tb_ramp_bist.sv
module tb_ramp_bist;
  localparam int KW     = 1;
  localparam int PERIOD = (1 << KW) * 256 + 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       gen_en = 1'b0, chk_en = 1'b0;
  logic [7:0] gen_data_o, chk_data_i = 8'h00;
  logic       gen_k_o, chk_k_i = 1'b0, chk_active_o, chk_err_o;

  int vectors = 0, miscompares = 0;
  int m_pos = 0, m_stage = 0, m_prev = 0;
  int exp_gd = 0, exp_gk = 0, m_active = 0, m_err = 0;

  always #4 clk = ~clk;

  ramp_bist #(.RAMP_CNT_W(KW)) dut (
    .clk(clk), .rst(rst), .gen_en(gen_en), .gen_data_o(gen_data_o), .gen_k_o(gen_k_o),
    .chk_en(chk_en), .chk_data_i(chk_data_i), .chk_k_i(chk_k_i),
    .chk_active_o(chk_active_o), .chk_err_o(chk_err_o)
  );

  task automatic cmp(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // mode 0: bench drives monitor, 1: loopback, 2: loopback with data byte +5
  task automatic step(input bit ge, input bit ce, input int mode,
                      input logic [7:0] sd, input logic sk, input string req);
    int d, k;
    @(negedge clk);
    gen_en = ge; chk_en = ce;
    if (mode == 0) begin d = sd; k = sk; end
    else begin
      d = gen_data_o; k = gen_k_o;
      if (mode == 2 && k == 0) d = (d + 5) % 256;
    end
    chk_data_i = d[7:0]; chk_k_i = k[0];
    // source model: position inside a period of data bytes then one comma
    if (rst || !ge) begin exp_gd = 0; exp_gk = 0; m_pos = 0; end
    else begin
      if (m_pos == PERIOD - 1) begin exp_gd = 'hBC; exp_gk = 1; end
      else begin exp_gd = m_pos % 256; exp_gk = 0; end
      m_pos = (m_pos + 1) % PERIOD;
    end
    // monitor model
    if (rst || !ce) begin m_active = 0; m_err = 0; m_stage = 0; m_prev = 0; end
    else if (k == 1) begin
      if (d == 'hBC) m_err = 0;
      if (m_active == 0) m_stage = 0;
    end else if (m_active == 0) begin
      if (m_stage == 2 && d == 2) begin m_active = 1; m_stage = 0; end
      else if (m_stage == 1 && d == 1) m_stage = 2;
      else m_stage = (d == 0) ? 1 : 0;
      m_prev = d;
    end else begin
      if (d != (m_prev + 1) % 256) m_err = 1;
      m_prev = d;
    end
    @(posedge clk); #1;
    cmp((rst || !ge) ? "R8" : (exp_gk == 1 ? "R3" : "R1"), "gen_data", gen_data_o, exp_gd);
    cmp("R2", "gen_k", gen_k_o, exp_gk);
    cmp(req, "active", chk_active_o, m_active);
    cmp(req, "err", chk_err_o, m_err);
  endtask

  task automatic seq(input logic [7:0] d, input logic k, input string req);
    step(1'b0, 1'b1, 0, d, k, req);
  endtask

  initial begin
    #1500000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R8 reset state
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1, 8'h00, 1'b0, "R8");
    rst = 1'b0;
    // R1 R2 R3 R4: clean loopback through two commas
    for (int i = 0; i < 1100; i++) step(1'b1, 1'b1, 1, 8'h00, 1'b0, "R4");
    // R5: one corrupted byte, then hold until the next comma clears it (R6)
    step(1'b1, 1'b1, 2, 8'h00, 1'b0, "R5");
    for (int i = 0; i < 600; i++) step(1'b1, 1'b1, 1, 8'h00, 1'b0, "R6");
    // R8: drop each enable mid-stream, then resume
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1, 8'h00, 1'b0, "R8");
    for (int i = 0; i < 2; i++) step(1'b0, 1'b0, 1, 8'h00, 1'b0, "R8");
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, 1, 8'h00, 1'b0, "R4");
    step(1'b0, 1'b0, 0, 8'h00, 1'b0, "R8");
    // R4: broken start, repeated 00, and a flagged byte inside the search
    seq(8'h00, 1'b0, "R4"); seq(8'h01, 1'b0, "R4"); seq(8'h03, 1'b0, "R4");
    seq(8'h00, 1'b0, "R4"); seq(8'h55, 1'b1, "R4"); seq(8'h01, 1'b0, "R4");
    seq(8'h00, 1'b0, "R4"); seq(8'h00, 1'b0, "R4"); seq(8'h01, 1'b0, "R4");
    seq(8'h02, 1'b0, "R4");
    // R7: non-comma control byte ignored, reference kept
    seq(8'h03, 1'b0, "R7"); seq(8'h55, 1'b1, "R7"); seq(8'h04, 1'b0, "R7");
    seq(8'h06, 1'b0, "R5"); seq(8'h55, 1'b1, "R7"); seq(8'h07, 1'b0, "R7");
    // R6: comma clears, reference held across it
    seq(8'hBC, 1'b1, "R6"); seq(8'h08, 1'b0, "R6");
    seq(8'hBC, 1'b1, "R6"); seq(8'hFF, 1'b0, "R5"); seq(8'hBC, 1'b1, "R6");
    seq(8'h00, 1'b0, "R6");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule